// File: doc/BRIEF.md
# Framed Synchronous Serial Shifter

This block is a master-side synchronous serial port. A host loads a transmit word and pulses a start strobe. The block then produces its own serial clock from the system clock and shifts the word out one bit at a time. At the same time it samples the serial input into a receive word. A frame pulse is driven in a window of programmable position and polarity. When the transfer finishes, the block raises a one-cycle done pulse and presents the received word.

Timing is counted in base periods. One base period is one full serial clock cycle, made of two half periods of `cfg_div + 1` system clocks each. Counting starts at the accepted start strobe.

- The data bits begin after a programmable start delay.
- The frame window is placed independently of the data bits.
- The serial clock can be held quiet for the final bit.

The configuration is captured when a transfer is accepted, so changes during a transfer have no effect on it.

Top module: `sync_serial_shifter`

## Requirements
- R1: The word length W is `cfg_len_m1 + 1` bits, or `ext_len_m1 + 1` bits when `cfg_len_ext` is 1. W ranges from 1 to 16.
- R2: Each serial clock half period lasts `cfg_div + 1` system clocks, so a base period is `2*(cfg_div+1)` clocks. A `cfg_div` of 0 behaves as 1.
- R3: With `cfg_msb_first` = 1, bit W-1 of the word is sent and received first. With 0, bit 0 goes first. Bit k of the transfer occupies base period D+k, and `sdo` holds that bit for the whole period.
- R4: While idle, `sclk` rests at `cfg_cpol`. In each bit period `sclk` is `~cpol` for the first half and `cpol` for the second half. The mid-period edge is the active edge: rising when `cfg_cpol` = 1, falling when 0. `sdi` is sampled on that edge.
- R5: With `cfg_mask_last` = 1, `sclk` stays at rest through the whole final bit period. The final input bit is still sampled internally.
- R6: The first bit starts D base periods after the strobe, where D = `cfg_delay`. A `cfg_delay` of 0 behaves as 1. Outside the bit periods `sdo` is 0.
- R7: The frame is active in base periods b with `cfg_frm_start` <= b < `cfg_frm_end`. It is never active when end <= start.
- R8: With `cfg_fpol` = 1 the frame output is high when active. With 0 it is low when active. Whenever the frame is not active, the output sits at the opposite level, including while idle.
- R9: With `cfg_enable` = 0 a start strobe is ignored and the outputs stay idle. Dropping enable during a transfer aborts it at once, with no done pulse.
- R10: A start strobe during a transfer is ignored, including any new `tx_word`.
- R11: A transfer lasts max(D+W, frame end if end > start) base periods. `done` pulses for one cycle as the last half period ends. `rx_word` is updated in that same cycle, and its bits W and above read 0.
- R12: `busy` is 1 from the clock after an accepted strobe until the transfer ends. Under reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe |
| tx_word | input | 16 | Word to transmit |
| sdi | input | 1 | Serial data input |
| cfg_enable | input | 1 | Block enable |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_len_m1 | input | 4 | Word length minus one |
| cfg_len_ext | input | 1 | Take the length from `ext_len_m1` |
| ext_len_m1 | input | 4 | Alternate word length minus one |
| cfg_div | input | 7 | Half-period divider |
| cfg_cpol | input | 1 | Active-edge select and rest level |
| cfg_mask_last | input | 1 | Suppress the clock in the final bit |
| cfg_delay | input | 2 | Start delay in base periods |
| cfg_fpol | input | 1 | Frame active level |
| cfg_frm_start | input | 6 | Frame start base period |
| cfg_frm_end | input | 6 | Frame end base period |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data output |
| frame | output | 1 | Frame pulse |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | 16 | Received word |

## Verification
The bench sweeps bit order, clock polarity, last-clock masking, frame polarity, word lengths from 1 to 16, and frame windows that are empty, inside the data, or longer than the data. It compares every cycle of `sclk`, `sdo`, `frame`, `busy` and `done` against an arithmetic model, and checks `rx_word` at completion.

Several faults would show up directly:
- A reversed bit index would scramble both `sdo` and `rx_word`.
- A missing mask would show an extra clock pulse in the last bit.
- An off-by-one in the delay or frame window would shift edges by a whole base period.
- Mishandling the reserved zero values of divider or delay would stretch or collapse the timing.

Strobes while busy, strobes while disabled, and an enable drop mid-transfer are each checked for a corrupted transfer, a spurious start, or a stray done pulse.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;
endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             half_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;

  // reserved divider value 0 runs as 1
  assign div_eff   = (div == '0) ? DIV_W'(1) : div;
  assign half_tick = run && (cnt == div_eff);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == div_eff) cnt <= '0;
    else cnt <= cnt + DIV_W'(1);
  end

  // a half period is never shorter than two clocks
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    half_tick |=> !half_tick);
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic              half_tick,
  input  logic [HALF_W-1:0] half_tot,
  output logic              accept,
  output logic              run,
  output logic [HALF_W-1:0] half_idx,
  output logic              last_tick,
  output logic              done
);
  run_state_e st;

  assign run       = (st == ST_RUN);
  assign accept    = en && start && !run;
  assign last_tick = run && half_tick && (half_idx == half_tot - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      half_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st <= ST_IDLE;
      end else if (accept) begin
        st       <= ST_RUN;
        half_idx <= '0;
      end else if (run && half_tick) begin
        if (last_tick) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end else begin
          half_idx <= half_idx + HALF_W'(1);
        end
      end
    end
  end

  p_disabled_stops_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !run && !done);
  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (run && en && start && !last_tick) |=> run);
  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_half_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (run && en && !half_tick) |=> (half_idx == $past(half_idx)));
endmodule

// File: rtl/ssp_pins.sv
module ssp_pins #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int POS_W  = 6,
  parameter int BW     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [BW-1:0]     base,
  input  logic              phase,
  input  logic              in_bits,
  input  logic              last_bit,
  input  logic [LEN_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] tx_q,
  input  logic              cpol_q,
  input  logic              fpol_q,
  input  logic              mask_q,
  input  logic [POS_W-1:0]  fs_q,
  input  logic [POS_W-1:0]  fe_q,
  input  logic              cpol_live,
  input  logic              fpol_live,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              frame_o
);
  logic sclk_d, sdo_d, frame_d, frm_on, clk_gate;

  assign clk_gate = in_bits && !(mask_q && last_bit);
  assign frm_on   = (fe_q > fs_q) && (base >= BW'(fs_q)) && (base < BW'(fe_q));

  always_comb begin
    if (!run) begin
      sclk_d  = cpol_live;
      sdo_d   = 1'b0;
      frame_d = ~fpol_live;
    end else begin
      sclk_d  = clk_gate ? (phase ? cpol_q : ~cpol_q) : cpol_q;
      sdo_d   = in_bits ? tx_q[bit_idx] : 1'b0;
      frame_d = frm_on ? fpol_q : ~fpol_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_o  <= 1'b0;
      sdo_o   <= 1'b0;
      frame_o <= 1'b0;
    end else begin
      sclk_o  <= sclk_d;
      sdo_o   <= sdo_d;
      frame_o <= frame_d;
    end
  end

  p_frame_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (run && !(fe_q > fs_q)) |=> (frame_o == !fpol_q));
  p_mask_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (run && mask_q && in_bits && last_bit) |=> (sclk_o == cpol_q));
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic [LEN_W-1:0]  bit_idx,
  input  logic              sdi,
  input  logic              finish,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      rx_word <= '0;
    end else begin
      if (clear) acc <= '0;
      else if (sample) acc[bit_idx] <= sdi;
      if (finish) rx_word <= acc;
    end
  end

  p_rx_stable_r11: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(rx_word));
endmodule

// File: rtl/sync_serial_shifter.sv
module sync_serial_shifter #(
  parameter int LEN_W  = 4,
  parameter int DIV_W  = 7,
  parameter int DLY_W  = 2,
  parameter int POS_W  = 6,
  parameter int DATA_W = 1 << LEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              sdi,
  input  logic              cfg_enable,
  input  logic              cfg_msb_first,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              cfg_len_ext,
  input  logic [LEN_W-1:0]  ext_len_m1,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_cpol,
  input  logic              cfg_mask_last,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic              cfg_fpol,
  input  logic [POS_W-1:0]  cfg_frm_start,
  input  logic [POS_W-1:0]  cfg_frm_end,
  output logic              sclk,
  output logic              sdo,
  output logic              frame,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int BW     = POS_W + 1;
  localparam int HALF_W = BW + 1;

  logic              accept, run, half_tick, last_tick;
  logic [HALF_W-1:0] half_idx, half_tot;
  logic [DATA_W-1:0] tx_q;
  logic [LEN_W-1:0]  len_q, bit_k, bit_idx;
  logic [DLY_W-1:0]  dly_q, dly_eff;
  logic [POS_W-1:0]  fs_q, fe_q;
  logic [DIV_W-1:0]  div_q;
  logic              msb_q, cpol_q, mask_q, fpol_q;
  logic [BW-1:0]     base, bits_end, frm_end, last_base, kk;
  logic              in_bits, last_bit, phase;

  // configuration captured when a transfer is accepted
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0; len_q <= '0; dly_q <= '0; fs_q <= '0; fe_q <= '0;
      div_q <= '0; msb_q <= 1'b0; cpol_q <= 1'b0; mask_q <= 1'b0; fpol_q <= 1'b0;
    end else if (accept) begin
      tx_q   <= tx_word;
      len_q  <= cfg_len_ext ? ext_len_m1 : cfg_len_m1;
      dly_q  <= cfg_delay;
      fs_q   <= cfg_frm_start;
      fe_q   <= cfg_frm_end;
      div_q  <= cfg_div;
      msb_q  <= cfg_msb_first;
      cpol_q <= cfg_cpol;
      mask_q <= cfg_mask_last;
      fpol_q <= cfg_fpol;
    end
  end

  // position decode shared by the pin and receive paths
  assign dly_eff   = (dly_q == '0) ? DLY_W'(1) : dly_q;
  assign base      = half_idx[HALF_W-1:1];
  assign phase     = half_idx[0];
  assign bits_end  = BW'(dly_eff) + BW'(len_q) + BW'(1);
  assign frm_end   = (fe_q > fs_q) ? BW'(fe_q) : '0;
  assign last_base = (frm_end > bits_end) ? frm_end : bits_end;
  assign half_tot  = {last_base, 1'b0};
  assign in_bits   = run && (base >= BW'(dly_eff)) && (base < bits_end);
  assign kk        = base - BW'(dly_eff);
  assign bit_k     = kk[LEN_W-1:0];
  assign last_bit  = (kk == BW'(len_q));
  assign bit_idx   = msb_q ? (len_q - bit_k) : bit_k;

  ssp_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(run), .div(div_q), .half_tick(half_tick));

  ssp_seq #(.HALF_W(HALF_W)) u_seq (
    .clk(clk), .rst(rst), .en(cfg_enable), .start(start), .half_tick(half_tick),
    .half_tot(half_tot), .accept(accept), .run(run), .half_idx(half_idx),
    .last_tick(last_tick), .done(done));

  ssp_pins #(.DATA_W(DATA_W), .LEN_W(LEN_W), .POS_W(POS_W), .BW(BW)) u_pins (
    .clk(clk), .rst(rst), .run(run), .base(base), .phase(phase),
    .in_bits(in_bits), .last_bit(last_bit), .bit_idx(bit_idx), .tx_q(tx_q),
    .cpol_q(cpol_q), .fpol_q(fpol_q), .mask_q(mask_q), .fs_q(fs_q), .fe_q(fe_q),
    .cpol_live(cfg_cpol), .fpol_live(cfg_fpol),
    .sclk_o(sclk), .sdo_o(sdo), .frame_o(frame));

  ssp_rx #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst(rst), .clear(accept),
    .sample(run && half_tick && !phase && in_bits),
    .bit_idx(bit_idx), .sdi(sdi), .finish(last_tick), .rx_word(rx_word));

  assign busy = run;

  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/tb_sync_serial_shifter.sv
module tb_sync_serial_shifter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] tx_word = '0;
  logic sdi = 1'b0;
  logic en = 1'b1, msb = 1'b0, lext = 1'b0, cp = 1'b0, mask = 1'b0, fp = 1'b0;
  logic [3:0] len = '0, elen = '0;
  logic [6:0] div = 7'd1;
  logic [1:0] dly = 2'd1;
  logic [5:0] fs = '0, fe = '0;
  logic sclk, sdo, frame, busy, done;
  logic [15:0] rx_word;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int gH, gD, gW;
  logic [15:0] gRx;

  always #2.5 clk = ~clk;

  sync_serial_shifter dut (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .sdi(sdi),
    .cfg_enable(en), .cfg_msb_first(msb), .cfg_len_m1(len), .cfg_len_ext(lext),
    .ext_len_m1(elen), .cfg_div(div), .cfg_cpol(cp), .cfg_mask_last(mask),
    .cfg_delay(dly), .cfg_fpol(fp), .cfg_frm_start(fs), .cfg_frm_end(fe),
    .sclk(sclk), .sdo(sdo), .frame(frame), .busy(busy), .done(done),
    .rx_word(rx_word));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic sdi_for(input int s);
    int b, k;
    b = (s / gH) / 2;
    k = b - gD;
    if (k >= 0 && k < gW) return msb ? gRx[gW-1-k] : gRx[k];
    return 1'b1;
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " R4 idle sclk"}, sclk, cp);
    chk({tag, " R8 idle frame"}, frame, !fp);
    chk({tag, " R6 idle sdo"}, sdo, 1'b0);
    chk({tag, " R9 no busy"}, busy, 1'b0);
    chk({tag, " R9 no done"}, done, 1'b0);
  endtask

  task automatic xfer(input logic [15:0] txv, input logic [15:0] rxv);
    int T, L, fend, b, ph, k;
    logic in_b, exp_sclk, exp_sdo, exp_frm;
    logic [15:0] exp_rx;
    gH = ((div == 0) ? 1 : int'(div)) + 1;
    gD = (dly == 0) ? 1 : int'(dly);
    gW = int'(lext ? elen : len) + 1;
    gRx = rxv;
    fend = (fe > fs) ? int'(fe) : 0;
    L = (gD + gW > fend) ? gD + gW : fend;
    T = 2 * L;
    exp_rx = '0;
    for (int i = 0; i < gW; i++) exp_rx[i] = rxv[i];
    @(negedge clk);
    tx_word = txv; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    sdi = sdi_for(0);
    for (int j = 0; j < T * gH; j++) begin
      @(posedge clk); @(negedge clk);
      // R10: a second strobe with another word mid-transfer
      if (j == 3) begin start = 1'b1; tx_word = ~txv; end
      else start = 1'b0;
      b = (j / gH) / 2;
      ph = (j / gH) % 2;
      k = b - gD;
      in_b = (k >= 0 && k < gW);
      if (in_b && !(mask && k == gW - 1)) exp_sclk = ph ? cp : !cp;
      else exp_sclk = cp;
      exp_sdo = in_b ? (msb ? txv[gW-1-k] : txv[k]) : 1'b0;
      exp_frm = (fe > fs && b >= int'(fs) && b < int'(fe)) ? fp : !fp;
      chk("R2 R4 R5 sclk", sclk, exp_sclk);
      chk("R1 R3 R6 R10 sdo", sdo, exp_sdo);
      chk("R7 R8 frame", frame, exp_frm);
      chk("R11 done", done, (j == T * gH - 1));
      chk("R12 busy", busy, (j + 1 < T * gH));
      if (j == T * gH - 1) chk("R1 R3 R11 rx_word", rx_word, exp_rx);
      sdi = sdi_for(j + 1);
    end
    @(posedge clk); @(negedge clk);
    check_idle("post");
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R12: reset state
    chk("R12 reset sclk", sclk, 0);
    chk("R12 reset frame", frame, 0);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset rx_word", rx_word, 0);
    chk("R12 reset done", done, 0);
    rst = 1'b0;
    @(negedge clk);
    check_idle("after reset");

    // sweep: order, polarity, mask, frame polarity, lengths, windows
    for (int c = 0; c < 16; c++) begin
      msb = c[0]; cp = c[1]; mask = c[2]; fp = c[3];
      len = 4'((c * 5 + 3) % 16);
      div = 7'(1 + c % 2);
      dly = 2'(1 + c % 3);
      fs = 6'(c % 4);
      fe = 6'((c * 3) % 9);
      @(negedge clk); @(negedge clk);
      xfer(16'(16'hA5C3 ^ (c * 16'h1357)), 16'(16'h3C96 + c * 16'h0F1D));
    end

    // R1: alternate length source, one-bit word
    lext = 1'b1; elen = 4'd6; len = 4'd2; msb = 1'b1;
    xfer(16'h00D9, 16'h0047);
    elen = 4'd0; msb = 1'b0;
    xfer(16'h0001, 16'hFFFF);
    lext = 1'b0;

    // R2 R6: reserved zero divider and delay
    div = 7'd0; dly = 2'd0; len = 4'd15; fs = 6'd0; fe = 6'd2;
    xfer(16'hBEEF, 16'h1234);

    // R7 R11: frame window longer than the data
    div = 7'd1; dly = 2'd3; len = 4'd3; fs = 6'd2; fe = 6'd12; mask = 1'b1;
    xfer(16'h000A, 16'h0005);

    // R9: strobe while disabled
    en = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check_idle("R9 disabled");
    end

    // R9: drop enable mid-transfer
    en = 1'b1;
    @(negedge clk); start = 1'b1; tx_word = 16'hFFFF;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R12 busy mid", busy, 1);
    en = 1'b0;
    @(negedge clk);
    chk("R9 abort busy", busy, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check_idle("R9 abort");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule